// File: doc/BRIEF.md
# Accelerator Register Fetch Sequencer

This block reads three configuration words from an accelerator's register space and hands the results to preprocessing logic further down the pipeline. A one-cycle start pulse opens the sequence. For each word the block raises a read request that carries an address and a byte length, and holds it until the responder accepts it. It then waits for the data beat and moves on to the next word. The three words are a flag word, the base address of a destination buffer and the buffer size. They are fetched one at a time, with one read outstanding at most.

After the third data beat the block loads the buffer address and the buffer size into output registers. It also raises a valid flag, but only when bit 0 of the fetched flag word is set. Downstream logic waits for the rising edge of that flag and then writes its results to the buffer. The outputs hold their values until a later sequence finishes or reset is applied. A new start clears the flag at once, so consumers never see a stale triple marked as valid while a refetch is in progress.

Top module: `arf_fetch_seq`

## Requirements
- R1: After reset, `req_avalid_o`, `buf_addr_o`, `buf_size_o` and `buf_valid_o` are all 0 and the block is idle.
- R2: When the block is idle and sees `start_i` high at a clock edge, `req_avalid_o` is high in the following cycle, with `req_addr_o` = BASE + 0x354.
- R3: The three requests of a sequence carry the addresses BASE + 0x354, BASE + 0x358 and BASE + 0x35C, in that order, and every request carries `req_len_o` = 4.
- R4: While `req_avalid_o` is high and `rsp_aready_i` is low, the request stays asserted with the same address. In the cycle after the edge that samples `rsp_aready_i` high, `req_avalid_o` is low.
- R5: No new request is raised before the data beat of the current read. For the first and second reads, the next request is asserted in the cycle right after the edge that samples `rsp_dvalid_i` high.
- R6: In the cycle after the edge that samples the third `rsp_dvalid_i`, the outputs are updated together: `buf_addr_o` takes the word read from 0x358, `buf_size_o` takes the word read from 0x35C, and `buf_valid_o` takes bit 0 of the word read from 0x354.
- R7: When bit 0 of the word read from 0x354 is 0, `buf_valid_o` stays low, but `buf_addr_o` and `buf_size_o` are still loaded.
- R8: A `start_i` pulse that arrives while a sequence is running is ignored. The running sequence keeps its address order and ends with the words it reads.
- R9: A `rsp_dvalid_i` beat outside the data wait does not change any output and raises no request. A `rsp_aready_i` pulse while no request is pending does not raise one either.
- R10: An accepted start drives `buf_valid_o` low in the next cycle. `buf_addr_o` and `buf_size_o` keep their old values until the new sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse for a fetch sequence |
| req_addr_o | output | AW (32) | Read request address |
| req_len_o | output | LW (8) | Read request length in bytes |
| req_avalid_o | output | 1 | Read request valid |
| rsp_aready_i | input | 1 | Responder accepts the request |
| rsp_data_i | input | DW (32) | Read data word |
| rsp_dvalid_i | input | 1 | Read data valid |
| buf_addr_o | output | DW (32) | Latched destination buffer address |
| buf_size_o | output | DW (32) | Latched destination buffer size |
| buf_valid_o | output | 1 | Latched valid flag for the buffer triple |

## Verification
Every result is due exactly one cycle after the edge that sampled its cause, because a single register stage sits on each path:
- the first request follows the start edge;
- the request drops after the accept edge;
- the next request follows a non-final data beat;
- the output triple and its flag follow the final data beat;
- the flag clears after an accepted start.

The bench drives inputs on falling edges and samples on the following falling edge, so each check falls in the cycle the requirement names. The responder model varies the accept delay and the data delay for each table row, so that the request holding and the wait for data are checked over several cycle counts.

// File: rtl/arf_pkg.sv
package arf_pkg;

    localparam int NUM_WORDS   = 3;
    localparam int SLOT_FLAG   = 0;
    localparam int SLOT_ADDR   = 1;
    localparam int SLOT_SIZE   = 2;
    localparam int REQ_BYTES   = 4;
    localparam int OFF_W       = 12;
    localparam logic [OFF_W-1:0] FIRST_OFFSET = 12'h354;
    localparam int IDX_W       = $clog2(NUM_WORDS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic acc_start;
        logic ret_fire;
        logic last_ret;
    } seq_evt_t;

    function automatic logic [OFF_W-1:0] word_offset(input logic [IDX_W-1:0] idx);
        return FIRST_OFFSET + OFF_W'(REQ_BYTES) * OFF_W'(idx);
    endfunction

endpackage

// File: rtl/arf_seq_ctrl.sv
module arf_seq_ctrl
    import arf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 aready_i,
    input  logic                 dvalid_i,
    output fetch_state_e         state_o,
    output logic [IDX_W-1:0]     idx_o,
    output seq_evt_t             evt_o
);

    fetch_state_e     state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    seq_evt_t         evt;

    always_comb begin
        evt.acc_start = (state_q == ST_IDLE) && start_i;
        evt.ret_fire  = (state_q == ST_DATA) && dvalid_i;
        evt.last_ret  = evt.ret_fire && (idx_q == IDX_W'(NUM_WORDS - 1));
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_REQ;
                    idx_d   = '0;
                end
            end
            ST_REQ: begin
                if (aready_i) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (dvalid_i) begin
                    if (idx_q == IDX_W'(NUM_WORDS - 1)) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_REQ;
                        idx_d   = idx_q + IDX_W'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign evt_o   = evt;

    // R8: a start during a running sequence leaves the word index untouched
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i && !dvalid_i) |=> $stable(idx_q));

    // R5: the index moves only on a data beat
    a_r5_idx_on_return: assert property (@(posedge clk) disable iff (rst)
        (idx_q != $past(idx_q)) |-> ($past(evt.ret_fire) || $past(evt.acc_start)));

endmodule

// File: rtl/arf_req_gen.sv
module arf_req_gen
    import arf_pkg::*;
#(
    parameter int              AW   = 32,
    parameter int              LW   = 8,
    parameter logic [AW-1:0]   BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fetch_state_e         state_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 aready_i,
    output logic [AW-1:0]        addr_o,
    output logic [LW-1:0]        len_o,
    output logic                 avalid_o
);

    localparam int PAD_W = AW - OFF_W;

    always_comb begin
        avalid_o = (state_i == ST_REQ);
        addr_o   = BASE + {{PAD_W{1'b0}}, word_offset(idx_i)};
        len_o    = LW'(REQ_BYTES);
    end

    // R3: every request is four bytes long
    a_r3_len_four: assert property (@(posedge clk) disable iff (rst)
        avalid_o |-> (len_o == LW'(REQ_BYTES)));

    // R4: an unaccepted request holds with the same address
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (avalid_o && !aready_i) |=> (avalid_o && $stable(addr_o)));

    // R4: an accepted request drops in the next cycle
    a_r4_drop: assert property (@(posedge clk) disable iff (rst)
        (avalid_o && aready_i) |=> !avalid_o);

endmodule

// File: rtl/arf_result_latch.sv
module arf_result_latch
    import arf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     idx_i,
    input  seq_evt_t             evt_i,
    input  logic                 dvalid_i,
    input  logic [DW-1:0]        data_i,
    output logic [DW-1:0]        buf_addr_o,
    output logic [DW-1:0]        buf_size_o,
    output logic                 buf_valid_o
);

    localparam int NUM_STAGED = NUM_WORDS - 1;

    logic [DW-1:0] staged [NUM_STAGED];

    for (genvar g = 0; g < NUM_STAGED; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                staged[g] <= '0;
            end else if (evt_i.ret_fire && idx_i == IDX_W'(g)) begin
                staged[g] <= data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_addr_o  <= '0;
            buf_size_o  <= '0;
            buf_valid_o <= 1'b0;
        end else if (evt_i.last_ret) begin
            buf_addr_o  <= staged[SLOT_ADDR];
            buf_size_o  <= data_i;
            buf_valid_o <= staged[SLOT_FLAG][0];
        end else if (evt_i.acc_start) begin
            buf_valid_o <= 1'b0;
        end
    end

    // R6: the flag rises only right after a final data beat
    a_r6_valid_after_return: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_valid_o) |-> ($past(evt_i.last_ret) && $past(dvalid_i)));

    // R10: an accepted start clears the flag
    a_r10_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        evt_i.acc_start |=> !buf_valid_o);

    // R9/R10: the triple moves only on a final data beat
    a_r9_hold_triple: assert property (@(posedge clk) disable iff (rst)
        !evt_i.last_ret |=> ($stable(buf_addr_o) && $stable(buf_size_o)));

endmodule

// File: rtl/arf_fetch_seq.sv
module arf_fetch_seq
    import arf_pkg::*;
#(
    parameter int            AW   = 32,
    parameter int            DW   = 32,
    parameter int            LW   = 8,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic [AW-1:0]    req_addr_o,
    output logic [LW-1:0]    req_len_o,
    output logic             req_avalid_o,
    input  logic             rsp_aready_i,
    input  logic [DW-1:0]    rsp_data_i,
    input  logic             rsp_dvalid_i,
    output logic [DW-1:0]    buf_addr_o,
    output logic [DW-1:0]    buf_size_o,
    output logic             buf_valid_o
);

    fetch_state_e     state;
    logic [IDX_W-1:0] idx;
    seq_evt_t         evt;

    arf_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .aready_i (rsp_aready_i),
        .dvalid_i (rsp_dvalid_i),
        .state_o  (state),
        .idx_o    (idx),
        .evt_o    (evt)
    );

    arf_req_gen #(.AW(AW), .LW(LW), .BASE(BASE)) u_req (
        .clk      (clk),
        .rst      (rst),
        .state_i  (state),
        .idx_i    (idx),
        .aready_i (rsp_aready_i),
        .addr_o   (req_addr_o),
        .len_o    (req_len_o),
        .avalid_o (req_avalid_o)
    );

    arf_result_latch #(.DW(DW)) u_latch (
        .clk         (clk),
        .rst         (rst),
        .idx_i       (idx),
        .evt_i       (evt),
        .dvalid_i    (rsp_dvalid_i),
        .data_i      (rsp_data_i),
        .buf_addr_o  (buf_addr_o),
        .buf_size_o  (buf_size_o),
        .buf_valid_o (buf_valid_o)
    );

    // R2: the first request follows an accepted start
    a_r2_first_request: assert property (@(posedge clk) disable iff (rst)
        evt.acc_start |=> (req_avalid_o && req_addr_o == BASE + AW'(FIRST_OFFSET)));

endmodule

// File: tb/test_arf_fetch_seq.sv
module test_arf_fetch_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int WATCHDOG_CYCLES = 20000;

    typedef struct packed {
        logic [31:0] w_flag;
        logic [31:0] w_addr;
        logic [31:0] w_size;
        logic [3:0]  rdy_dly;
        logic [3:0]  dat_dly;
        logic        mid_start;
        logic        exp_valid;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0001, 32'h8000_1000, 32'h0003_0000, 4'd0, 4'd0, 1'b0, 1'b1},
        '{32'h0000_0000, 32'h1234_5678, 32'h0000_0040, 4'd2, 4'd3, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 32'hDEAD_BEE0, 32'hFFFF_FFFF, 4'd1, 4'd0, 1'b1, 1'b1},
        '{32'h0000_0002, 32'h0000_0000, 32'h0000_0000, 4'd3, 4'd1, 1'b0, 1'b0},
        '{32'h0000_0001, 32'h4000_0000, 32'h00C0_0000, 4'd0, 4'd2, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] req_addr_o;
    logic [LW-1:0] req_len_o;
    logic          req_avalid_o;
    logic          rsp_aready_i = 1'b0;
    logic [DW-1:0] rsp_data_i = '0;
    logic          rsp_dvalid_i = 1'b0;
    logic [DW-1:0] buf_addr_o;
    logic [DW-1:0] buf_size_o;
    logic          buf_valid_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [DW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_size = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    arf_fetch_seq #(.AW(AW), .DW(DW), .LW(LW), .BASE('0)) i_arf_fetch_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .req_addr_o   (req_addr_o),
        .req_len_o    (req_len_o),
        .req_avalid_o (req_avalid_o),
        .rsp_aready_i (rsp_aready_i),
        .rsp_data_i   (rsp_data_i),
        .rsp_dvalid_i (rsp_dvalid_i),
        .buf_addr_o   (buf_addr_o),
        .buf_size_o   (buf_size_o),
        .buf_valid_o  (buf_valid_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_seq(input vec_t v);
        logic [31:0] words [3];
        words[0] = v.w_flag;
        words[1] = v.w_addr;
        words[2] = v.w_size;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(req_avalid_o == 1'b1, "R2 request after start", 64'(req_avalid_o), 64'd1);
        check(buf_valid_o == 1'b0, "R10 valid cleared by start", 64'(buf_valid_o), 64'd0);
        check(buf_addr_o == prev_addr, "R10 addr held", 64'(buf_addr_o), 64'(prev_addr));
        for (int i = 0; i < 3; i++) begin
            check(req_addr_o == 32'h354 + 32'(4 * i), "R3 request address", 64'(req_addr_o), 64'(32'h354 + 32'(4 * i)));
            check(req_len_o == 8'd4, "R3 request length", 64'(req_len_o), 64'd4);
            for (int d = 0; d < int'(v.rdy_dly); d++) begin
                @(negedge clk);
                check(req_avalid_o == 1'b1 && req_addr_o == 32'h354 + 32'(4 * i), "R4 request held",
                      64'(req_addr_o), 64'(32'h354 + 32'(4 * i)));
            end
            rsp_aready_i = 1'b1;
            if (v.mid_start && i == 1) start_i = 1'b1;
            @(negedge clk);
            rsp_aready_i = 1'b0;
            start_i = 1'b0;
            check(req_avalid_o == 1'b0, "R4 request dropped after accept", 64'(req_avalid_o), 64'd0);
            for (int d = 0; d < int'(v.dat_dly); d++) begin
                if (v.mid_start && d == 0) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                check(req_avalid_o == 1'b0, "R5 no request before data", 64'(req_avalid_o), 64'd0);
            end
            check(buf_valid_o == 1'b0, "R10 valid low during fetch", 64'(buf_valid_o), 64'd0);
            rsp_data_i = words[i];
            rsp_dvalid_i = 1'b1;
            @(negedge clk);
            rsp_dvalid_i = 1'b0;
            rsp_data_i = 32'hA5A5_A5A5;
            if (i < 2) begin
                check(req_avalid_o == 1'b1, "R5 next request after data", 64'(req_avalid_o), 64'd1);
            end else begin
                check(req_avalid_o == 1'b0, "R8 no extra request", 64'(req_avalid_o), 64'd0);
                check(buf_addr_o == v.w_addr, "R6 buffer address", 64'(buf_addr_o), 64'(v.w_addr));
                check(buf_size_o == v.w_size, "R6 buffer size", 64'(buf_size_o), 64'(v.w_size));
                check(buf_valid_o == v.exp_valid, v.exp_valid ? "R6 valid flag" : "R7 valid stays low",
                      64'(buf_valid_o), 64'(v.exp_valid));
            end
        end
        prev_addr = v.w_addr;
        prev_size = v.w_size;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_avalid_o == 1'b0, "R1 reset avalid", 64'(req_avalid_o), 64'd0);
        check(buf_addr_o == '0 && buf_size_o == '0, "R1 reset triple", 64'(buf_addr_o), 64'd0);
        check(buf_valid_o == 1'b0, "R1 reset valid", 64'(buf_valid_o), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_avalid_o == 1'b0, "R1 idle after reset", 64'(req_avalid_o), 64'd0);

        for (int k = 0; k < NVEC; k++) begin
            run_seq(VECS[k]);
            repeat (2) @(negedge clk);
        end

        // R9: stray data beat and stray accept while idle
        rsp_data_i = 32'h1111_2222;
        rsp_dvalid_i = 1'b1;
        @(negedge clk);
        rsp_dvalid_i = 1'b0;
        check(buf_addr_o == prev_addr && buf_size_o == prev_size, "R9 stray data ignored",
              64'(buf_addr_o), 64'(prev_addr));
        check(buf_valid_o == 1'b1, "R9 valid unchanged by stray data", 64'(buf_valid_o), 64'd1);
        check(req_avalid_o == 1'b0, "R9 no request from stray data", 64'(req_avalid_o), 64'd0);
        rsp_aready_i = 1'b1;
        @(negedge clk);
        rsp_aready_i = 1'b0;
        @(negedge clk);
        check(req_avalid_o == 1'b0, "R9 stray accept ignored", 64'(req_avalid_o), 64'd0);

        // R1: reset in the middle of a fetch clears everything
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(req_avalid_o == 1'b0 && buf_valid_o == 1'b0 && buf_addr_o == '0, "R1 reset mid fetch",
              64'(buf_addr_o), 64'd0);
        rst = 1'b0;
        prev_addr = '0;
        prev_size = '0;
        run_seq(VECS[0]);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule